// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence of a short memory burst. A starting address is captured whenever either of two independent, active-low address strobes is asserted at a rising clock edge. The two strobes stand for two separate requesters. Later beats of the burst are produced internally, one per clock, while an active-low advance input is held. Only the low-order burst field of the address changes during a burst. The upper address bits and a captured chip-enable pass through untouched.

A run-time order select chooses one of two beat orders. The linear order is a wrapping increment of the low field. The interleaved order XORs the starting low field with the beat count. The order is captured together with the start address, so a change on the select input only affects the next burst. The block is meant to sit in front of a pipelined memory array, where it supplies the beat address after the first access has been launched.

Top module: `burst_seq_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `cur_addr` is 0, `beat_idx` is 0 and `chip_sel` is 0.
- R2: When `proc_strobe_n` or `ctrl_strobe_n` is low at a rising edge, that edge captures `start_addr` and `chip_en`. From then on `cur_addr` equals `start_addr`, `beat_idx` is 0 and `chip_sel` equals the captured `chip_en`.
- R3: When a strobe and `advance_n` are both low at the same edge, only the load of R2 happens and the beat does not step.
- R4: When `advance_n` is low and both strobes are high at an edge, `beat_idx` steps by one, modulo 2^BEAT_W (modulo 4 by default).
- R5: With linear order captured (`order_sel` = 0 at load), the low BEAT_W bits of `cur_addr` equal (start low bits + `beat_idx`) modulo 2^BEAT_W.
- R6: With interleaved order captured (`order_sel` = 1 at load), the low BEAT_W bits of `cur_addr` equal start low bits XOR `beat_idx`.
- R7: The upper bits `cur_addr[ADDR_W-1:BEAT_W]` never change except at a load, so no step carries into them. After the last beat, one more step returns the address to the start address and `beat_idx` to 0.
- R8: When `advance_n` and both strobes are high at an edge, `cur_addr`, `beat_idx` and `chip_sel` keep their values.
- R9: `order_sel` is sampled only at a load. A change on it during a burst does not alter that burst's sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_strobe_n | input | 1 | First requester's address strobe, active low |
| ctrl_strobe_n | input | 1 | Second requester's address strobe, active low |
| advance_n | input | 1 | Step to the next beat, active low |
| order_sel | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| chip_en | input | 1 | Chip enable, captured at a load |
| start_addr | input | ADDR_W | Burst start address |
| cur_addr | output | ADDR_W | Current beat address |
| beat_idx | output | BEAT_W | Beats stepped since the load |
| chip_sel | output | 1 | Chip enable captured at the last load |

## Verification
The bench builds the block with ADDR_W = 12 and BEAT_W = 2. With these values all four start offsets in both orders fit in one small vector table, each checked beat by beat through the wrap back to the start. A narrow upper field lets the bench use an all-ones start address, so a carry out of the burst field into the upper bits would show up at once. The same small widths keep the cases short where strobe and advance collide, the order select changes mid-burst, and reset arrives inside a burst.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  // Widest burst field the helper functions cover.
  localparam int SEQ_MAX_W = 8;

  // Wrapping-increment offset: start plus beat, truncated by the caller.
  function automatic logic [SEQ_MAX_W-1:0] seq_linear(
    input logic [SEQ_MAX_W-1:0] start_low,
    input logic [SEQ_MAX_W-1:0] beat
  );
    return start_low + beat;
  endfunction

  // Interleaved offset: start bits flipped where the beat count has ones.
  function automatic logic [SEQ_MAX_W-1:0] seq_interleave(
    input logic [SEQ_MAX_W-1:0] start_low,
    input logic [SEQ_MAX_W-1:0] beat
  );
    return start_low ^ beat;
  endfunction

endpackage

// File: rtl/burst_strobe_decode.sv
`timescale 1ns/1ps
module burst_strobe_decode (
  input  logic proc_strobe_n,
  input  logic ctrl_strobe_n,
  input  logic advance_n,
  output logic load_evt,
  output logic step_evt
);

  // Either strobe loads; advance acts only without a strobe.
  always_comb begin
    load_evt = !proc_strobe_n || !ctrl_strobe_n;
    step_evt = !advance_n && !load_evt;
  end

endmodule

// File: rtl/burst_beat_counter.sv
`timescale 1ns/1ps
module burst_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              step_evt,
  output logic [BEAT_W-1:0] cnt,
  output logic              wrap_evt
);

  localparam logic [BEAT_W-1:0] ONE  = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load_evt) cnt <= '0;
    else if (step_evt) cnt <= cnt + ONE;
  end

  // Event: the step that closes a burst and returns to beat zero.
  assign wrap_evt = step_evt && (cnt == LAST);

  assert_load_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt == '0));

  assert_step_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (cnt == $past(cnt) + ONE));

  assert_wrap_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0));

  assert_hold_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> $stable(cnt));

endmodule

// File: rtl/burst_start_reg.sv
`timescale 1ns/1ps
module burst_start_reg #(
  parameter int ADDR_W = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_evt,
  input  logic [ADDR_W-1:0]           start_addr,
  input  logic                        order_sel,
  input  logic                        chip_en,
  output logic [ADDR_W-1:0]           base_q,
  output burst_seq_pkg::burst_order_e order_q,
  output logic                        chip_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= burst_seq_pkg::ORDER_LINEAR;
      chip_q  <= 1'b0;
    end else if (load_evt) begin
      base_q  <= start_addr;
      order_q <= burst_seq_pkg::burst_order_e'(order_sel);
      chip_q  <= chip_en;
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (base_q == $past(start_addr)) && (chip_q == $past(chip_en)));

  assert_order_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(order_q));

  assert_chip_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(chip_q));

endmodule

// File: rtl/burst_addr_map.sv
`timescale 1ns/1ps
module burst_addr_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0]           start_low,
  input  logic [BEAT_W-1:0]           beat,
  input  burst_seq_pkg::burst_order_e order,
  output logic [BEAT_W-1:0]           low_addr
);

  localparam int MW = burst_seq_pkg::SEQ_MAX_W;

  logic [MW-1:0]     lin_full;
  logic [MW-1:0]     ilv_full;
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;
  logic [BEAT_W-1:0] ilv_bits;

  always_comb begin
    lin_full = burst_seq_pkg::seq_linear(MW'(start_low), MW'(beat));
    ilv_full = burst_seq_pkg::seq_interleave(MW'(start_low), MW'(beat));
    lin_low  = lin_full[BEAT_W-1:0];
    ilv_low  = ilv_full[BEAT_W-1:0];
  end

  // Per-bit form of the interleave, kept as an independent cross-check.
  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv_bit
    assign ilv_bits[i] = start_low[i] ^ beat[i];
  end

  assign low_addr = (order == burst_seq_pkg::ORDER_INTERLEAVE) ? ilv_low : lin_low;

  always_comb begin
    assert_ilv_match_R6: assert (ilv_bits == ilv_low);
  end

endmodule

// File: rtl/burst_seq_gen.sv
`timescale 1ns/1ps
module burst_seq_gen #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              advance_n,
  input  logic              order_sel,
  input  logic              chip_en,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              chip_sel
);

  localparam int UP_W = ADDR_W - BEAT_W;

  // Named internal events for the assertions.
  logic                        load_evt;
  logic                        step_evt;
  logic                        wrap_evt;
  logic [ADDR_W-1:0]           base_q;
  burst_seq_pkg::burst_order_e order_q;
  logic [BEAT_W-1:0]           cnt;
  logic [BEAT_W-1:0]           low_addr;

  burst_strobe_decode u_decode (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .load_evt      (load_evt),
    .step_evt      (step_evt)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_evt   (load_evt),
    .start_addr (start_addr),
    .order_sel  (order_sel),
    .chip_en    (chip_en),
    .base_q     (base_q),
    .order_q    (order_q),
    .chip_q     (chip_sel)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .cnt      (cnt),
    .wrap_evt (wrap_evt)
  );

  burst_addr_map #(.BEAT_W(BEAT_W)) u_map (
    .start_low (base_q[BEAT_W-1:0]),
    .beat      (cnt),
    .order     (order_q),
    .low_addr  (low_addr)
  );

  assign cur_addr = {base_q[ADDR_W-1:BEAT_W], low_addr};
  assign beat_idx = cnt;

  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(cur_addr[ADDR_W-1:ADDR_W-UP_W]));

  assert_back_to_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cur_addr == base_q));

  assert_strobe_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !advance_n) |=> (beat_idx == '0));

endmodule

// File: tb/burst_seq_gen_test.sv
`timescale 1ns/1ps
module burst_seq_gen_test;
  localparam int AW = 12;
  localparam int BW = 2;

  // Entry: {order, start_low[1:0], beat0, beat1, beat2, beat3}, each beat 2 bits.
  localparam logic [10:0] VEC [8] = '{
    11'b0_00_00_01_10_11,
    11'b0_01_01_10_11_00,
    11'b0_10_10_11_00_01,
    11'b0_11_11_00_01_10,
    11'b1_00_00_01_10_11,
    11'b1_01_01_00_11_10,
    11'b1_10_10_11_00_01,
    11'b1_11_11_10_01_00
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          p_n = 1'b1, c_n = 1'b1, adv_n = 1'b1, ord = 1'b0, ce = 1'b0;
  logic [AW-1:0] start = '0;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] beat_idx;
  logic          chip_sel;
  int            n_cmp = 0;
  int            n_bad = 0;

  always #2.5 clk = ~clk;

  burst_seq_gen #(.ADDR_W(AW), .BEAT_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .proc_strobe_n(p_n), .ctrl_strobe_n(c_n),
    .advance_n(adv_n), .order_sel(ord), .chip_en(ce), .start_addr(start),
    .cur_addr(cur_addr), .beat_idx(beat_idx), .chip_sel(chip_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Load on one strobe; optionally hold advance low in the same cycle.
  task automatic do_load(input logic [AW-1:0] a, input logic m, input logic e,
                         input bit use_proc, input bit adv_too);
    @(negedge clk);
    start = a; ord = m; ce = e;
    if (use_proc) p_n = 1'b0; else c_n = 1'b0;
    adv_n = adv_too ? 1'b0 : 1'b1;
    @(negedge clk);
    p_n = 1'b1; c_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic do_step();
    adv_n = 1'b0;
    @(negedge clk);
    adv_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [10:0]     e;
    logic [AW-BW-1:0] up;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 addr", cur_addr, 0);
    chk("R1 beat", beat_idx, 0);
    chk("R1 sel", chip_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr after release", cur_addr, 0);

    // Table: all start offsets, both orders, full burst and wrap
    for (int v = 0; v < 8; v++) begin
      e  = VEC[v];
      up = 10'h2A5 ^ 10'(v);
      do_load({up, e[9:8]}, e[10], 1'b1, (v % 2) == 0, 1'b0);
      chk("R2 sel", chip_sel, 1);
      for (int k = 0; k < 4; k++) begin
        chk(e[10] ? "R6 addr" : "R5 addr", cur_addr, {up, e[7-2*k -: 2]});
        chk("R4 beat", beat_idx, k);
        do_step();
      end
      chk("R7 wrap addr", cur_addr, {up, e[9:8]});
      chk("R7 wrap beat", beat_idx, 0);
    end

    // R8: hold without advance or strobe
    do_load(12'h5A1, 1'b0, 1'b1, 1'b1, 1'b0);
    do_step();
    repeat (3) @(negedge clk);
    chk("R8 hold addr", cur_addr, 12'h5A2);
    chk("R8 hold beat", beat_idx, 1);

    // R3: strobe with advance at the same edge loads only
    do_load(12'h3C2, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R3 addr", cur_addr, 12'h3C2);
    chk("R3 beat", beat_idx, 0);
    chk("R2 sel cleared", chip_sel, 0);

    // R9: order flip mid-burst ignored (linear start 1, step -> 2, not 0)
    do_load(12'h101, 1'b0, 1'b1, 1'b0, 1'b0);
    ord = 1'b1;
    do_step();
    chk("R9 order kept", cur_addr, 12'h102);
    do_step();
    chk("R9 order kept 2", cur_addr, 12'h103);

    // R7: no carry into upper bits from an all-ones start
    do_load(12'hFFF, 1'b0, 1'b1, 1'b1, 1'b0);
    do_step();
    chk("R7 no carry", cur_addr, 12'hFFC);
    chk("R7 no carry beat", beat_idx, 1);

    // R1: reset inside a burst
    do_step();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid addr", cur_addr, 0);
    chk("R1 mid beat", beat_idx, 0);
    chk("R1 mid sel", chip_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule